// File: doc/BRIEF.md
# Calibrated Multichannel Converter Code Bank

This block keeps the digital codes for a bank of 32 voltage-output converter channels, each 12 bits wide. A host writes through a simple write port that picks one of four targets with a select field: the data code, the gain word or the offset word of one channel, or the one clear code shared by all channels. A data write is not stored as written. A shared sequential engine corrects it with that channel's gain and offset, and the result goes into the channel's input register.

Each channel also has an output register that drives the converter. An active-low load strobe copies every input register to its output register on the same clock edge, so all outputs change together. While a correction is being computed, the active-low busy flag is low. A load request made in that time is held back and carried out on the first edge after busy returns high. One data write can wait behind the write in progress. A further write is dropped and sets a sticky overrun flag. An active-low clear input loads every output register with the programmable clear code. Clear wins over any load request in the same cycle and cancels a load that is held back.

Top module: `dac_regbank`

## Requirements
- R1: After reset, `busy_n` is 1, `overrun` is 0, and every output code, input register and the clear code are 0. Every gain word resets to 4095 and every offset word to 2048, so a data write is stored unchanged until those words are written.
- R2: A data write (`wr_sel` = 0) stores its corrected code in the input register of channel `wr_ch` and does not change `dac_codes`. Channel k occupies bits [12k+11:12k] of `dac_codes`.
- R3: A data write accepted while the engine is idle drives `busy_n` low for exactly 16 cycles, starting with the cycle after the write edge. The input register is updated on the edge that ends those 16 cycles.
- R4: When `ldac_n` is low and `busy_n` is high in a cycle, with `clr_n` high, every output register takes its input register's value at the next edge.
- R5: If `ldac_n` is low in a cycle while `busy_n` is low, the load is held back. It takes place on the first edge at which `busy_n` is sampled high, and the outputs do not change before that edge.
- R6: The stored code is data*(gain+1)/4096 + offset - 2048, with the division truncated and the result saturated to 0..4095.
- R7: Gain writes (`wr_sel` = 1), offset writes (`wr_sel` = 2) and clear-code writes (`wr_sel` = 3) take effect at once, do not drive `busy_n` low, and apply to computations started afterwards.
- R8: A data write that arrives while a computation runs is held in a one-entry queue and computed as soon as the running computation ends. `busy_n` stays low without a gap until the queued computation ends.
- R9: A data write that arrives while the queue is full is dropped and sets `overrun`, which stays 1 until reset.
- R10: When `clr_n` is low in a cycle, every output register takes the clear code at the next edge. This wins over a concurrent load request and cancels any held-back load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_sel | input | 2 | Write target: 0 data, 1 gain, 2 offset, 3 clear code |
| wr_ch | input | 5 | Channel addressed by a data, gain or offset write |
| wr_data | input | 12 | Write value |
| ldac_n | input | 1 | Active-low load request, input registers to output registers |
| clr_n | input | 1 | Active-low clear, output registers to clear code |
| busy_n | output | 1 | Low while a correction is being computed or queued |
| overrun | output | 1 | Sticky flag, set when a data write is dropped |
| dac_codes | output | 384 | All output registers, channel k in bits [12k+11:12k] |

## Verification
The assertions assume that `ldac_n` and `clr_n` are synchronous level inputs, sampled on each rising edge. They also assume that the gain and offset of a channel are not rewritten while a computation for that channel is running, so the operands captured at the start stay the ones the host intended. The stimulus changes every input on the falling edge and holds each strobe low for one full cycle. It writes gain and offset words only while the engine is idle, and it sends back-to-back data writes only in the queue and overrun scenarios.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_CLRC = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dac_cal_engine.sv
module dac_cal_engine #(
  parameter int W           = 12,
  parameter int NCH         = 32,
  parameter int CALC_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] s_ch,
  input  logic [W-1:0]           s_data,
  input  logic [W-1:0]           s_gain,
  input  logic [W-1:0]           s_offs,
  output logic                   active,
  output logic                   done,
  output logic [$clog2(NCH)-1:0] res_ch,
  output logic [W-1:0]           res_code
);
  localparam int CH_W  = $clog2(NCH);
  localparam int CNT_W = $clog2(CALC_CYCLES);
  localparam int AW    = 2 * W + 1;
  localparam int SW    = W + 3;

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [AW-1:0]    mcand_q, mcand_d;
  logic [W:0]       mplier_q, mplier_d;
  logic [AW-1:0]    acc_q, acc_d;
  logic [W-1:0]     offs_q, offs_d;

  logic [W:0]       prod;
  logic [SW-1:0]    sum;

  assign done = act_q && (cnt_q == CNT_W'(CALC_CYCLES - 1));

  // next state: shift-add multiply, one multiplier bit per cycle
  always_comb begin
    act_d    = act_q;
    cnt_d    = cnt_q;
    ch_d     = ch_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    offs_d   = offs_q;
    if (start) begin
      act_d    = 1'b1;
      cnt_d    = '0;
      ch_d     = s_ch;
      mcand_d  = AW'(s_data);
      mplier_d = (W+1)'(s_gain) + (W+1)'(1);
      acc_d    = '0;
      offs_d   = s_offs;
    end else if (act_q) begin
      if (mplier_q[0]) acc_d = acc_q + mcand_q;
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
      cnt_d    = cnt_q + CNT_W'(1);
      if (done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cnt_q    <= '0;
      ch_q     <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      offs_q   <= '0;
    end else begin
      act_q    <= act_d;
      cnt_q    <= cnt_d;
      ch_q     <= ch_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
      offs_q   <= offs_d;
    end
  end

  // scale, add offset, remove mid-scale bias, saturate
  assign prod = acc_q[AW-1:W];
  assign sum  = SW'(prod) + SW'(offs_q) - SW'(1 << (W - 1));

  always_comb begin
    if (sum[SW-1])
      res_code = '0;
    else if (sum[SW-2:0] > (SW-1)'((1 << W) - 1))
      res_code = '1;
    else
      res_code = sum[W-1:0];
  end

  assign active = act_q;
  assign res_ch = ch_q;
endmodule

// File: rtl/dac_wr_queue.sv
module dac_wr_queue #(
  parameter int W   = 12,
  parameter int NCH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic                   pop,
  input  logic [$clog2(NCH)-1:0] in_ch,
  input  logic [W-1:0]           in_data,
  output logic                   q_valid,
  output logic [$clog2(NCH)-1:0] q_ch,
  output logic [W-1:0]           q_data,
  output logic                   overrun
);
  localparam int CH_W = $clog2(NCH);

  logic            vld_q, vld_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [W-1:0]    dat_q, dat_d;
  logic            ovr_q, ovr_d;

  always_comb begin
    vld_d = vld_q;
    ch_d  = ch_q;
    dat_d = dat_q;
    ovr_d = ovr_q;
    if (pop) vld_d = 1'b0;
    if (push) begin
      if (!vld_q || pop) begin
        vld_d = 1'b1;
        ch_d  = in_ch;
        dat_d = in_data;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
      dat_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ch_q  <= ch_d;
      dat_q <= dat_d;
      ovr_q <= ovr_d;
    end
  end

  assign q_valid = vld_q;
  assign q_ch    = ch_q;
  assign q_data  = dat_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/dac_chan_store.sv
module dac_chan_store #(
  parameter int W   = 12,
  parameter int NCH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gain_we,
  input  logic                   offs_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [W-1:0]           cfg_data,
  input  logic                   in_we,
  input  logic [$clog2(NCH)-1:0] in_ch,
  input  logic [W-1:0]           in_code,
  input  logic                   xfer,
  input  logic                   clr,
  input  logic [W-1:0]           clr_code,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  output logic [W-1:0]           rd_gain,
  output logic [W-1:0]           rd_offs,
  output logic [NCH*W-1:0]       dac_codes
);
  localparam int CH_W = $clog2(NCH);
  localparam logic [W-1:0] GAIN_RST = W'((1 << W) - 1);
  localparam logic [W-1:0] OFFS_RST = W'(1 << (W - 1));

  logic [W-1:0] gain_q [NCH];
  logic [W-1:0] offs_q [NCH];
  logic [W-1:0] in_q   [NCH];
  logic [W-1:0] dac_q  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel_cfg, sel_in;
    assign sel_cfg = (cfg_ch == CH_W'(g));
    assign sel_in  = (in_ch  == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gain_q[g] <= GAIN_RST;
      else if (gain_we && sel_cfg) gain_q[g] <= cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  offs_q[g] <= OFFS_RST;
      else if (offs_we && sel_cfg) offs_q[g] <= cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               in_q[g] <= '0;
      else if (in_we && sel_in) in_q[g] <= in_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dac_q[g] <= '0;
      else if (clr)  dac_q[g] <= clr_code;
      else if (xfer) dac_q[g] <= in_q[g];
    end

    assign dac_codes[g*W +: W] = dac_q[g];
  end

  assign rd_gain = gain_q[rd_ch];
  assign rd_offs = offs_q[rd_ch];
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int W           = 12,
  parameter int NCH         = 32,
  parameter int CALC_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [W-1:0]           wr_data,
  input  logic                   ldac_n,
  input  logic                   clr_n,
  output logic                   busy_n,
  output logic                   overrun,
  output logic [NCH*W-1:0]       dac_codes
);
  localparam int CH_W = $clog2(NCH);

  logic            srst_n;
  logic            data_wr, gain_we, offs_we, clrc_we;
  logic            eng_active, eng_done, eng_free;
  logic            start, push, pop;
  logic [CH_W-1:0] start_ch, res_ch, q_ch;
  logic [W-1:0]    start_data, res_code, q_data;
  logic [W-1:0]    rd_gain, rd_offs;
  logic            q_valid;
  logic            busy, xfer, clr, ldac_req;
  logic            pend_q, pend_d;
  logic [W-1:0]    clear_code, clrc_d;

  dac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // write decode
  assign data_wr = wr_en && (wr_sel == SEL_DATA);
  assign gain_we = wr_en && (wr_sel == SEL_GAIN);
  assign offs_we = wr_en && (wr_sel == SEL_OFFS);
  assign clrc_we = wr_en && (wr_sel == SEL_CLRC);

  // engine scheduling: direct start, queue hand-off, or queue push
  assign eng_free   = !eng_active || (eng_done && !q_valid);
  assign pop        = eng_done && q_valid;
  assign push       = data_wr && !eng_free;
  assign start      = pop || (data_wr && eng_free);
  assign start_ch   = pop ? q_ch   : wr_ch;
  assign start_data = pop ? q_data : wr_data;

  dac_wr_queue #(.W(W), .NCH(NCH)) u_queue (
    .clk(clk), .rst_n(srst_n),
    .push(push), .pop(pop),
    .in_ch(wr_ch), .in_data(wr_data),
    .q_valid(q_valid), .q_ch(q_ch), .q_data(q_data),
    .overrun(overrun)
  );

  dac_cal_engine #(.W(W), .NCH(NCH), .CALC_CYCLES(CALC_CYCLES)) u_engine (
    .clk(clk), .rst_n(srst_n),
    .start(start), .s_ch(start_ch), .s_data(start_data),
    .s_gain(rd_gain), .s_offs(rd_offs),
    .active(eng_active), .done(eng_done),
    .res_ch(res_ch), .res_code(res_code)
  );

  // load/clear control
  assign busy     = eng_active || q_valid;
  assign busy_n   = !busy;
  assign ldac_req = !ldac_n;
  assign clr      = !clr_n;
  assign xfer     = !clr && !busy && (ldac_req || pend_q);

  always_comb begin
    pend_d = pend_q;
    if (clr || xfer)         pend_d = 1'b0;
    else if (ldac_req && busy) pend_d = 1'b1;
    clrc_d = clrc_we ? wr_data : clear_code;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q     <= 1'b0;
      clear_code <= '0;
    end else begin
      pend_q     <= pend_d;
      clear_code <= clrc_d;
    end
  end

  dac_chan_store #(.W(W), .NCH(NCH)) u_store (
    .clk(clk), .rst_n(srst_n),
    .gain_we(gain_we), .offs_we(offs_we),
    .cfg_ch(wr_ch), .cfg_data(wr_data),
    .in_we(eng_done), .in_ch(res_ch), .in_code(res_code),
    .xfer(xfer), .clr(clr), .clr_code(clear_code),
    .rd_ch(start_ch), .rd_gain(rd_gain), .rd_offs(rd_offs),
    .dac_codes(dac_codes)
  );
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int W   = 12,
  parameter int NCH = 32
) (
  input logic             clk,
  input logic             srst_n,
  input logic             busy_n,
  input logic             overrun,
  input logic             ldac_n,
  input logic             clr_n,
  input logic             pend_q,
  input logic [W-1:0]     clear_code,
  input logic [NCH*W-1:0] dac_codes
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      low_cnt <= '0;
    else if (!busy_n) low_cnt <= low_cnt + 8'd1;
    else              low_cnt <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy_n) |-> (low_cnt != 8'd0) && (low_cnt[3:0] == 4'd0)); // R3

  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_n && clr_n) |=> $stable(dac_codes)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_n && ldac_n && !pend_q) |=> $stable(dac_codes)); // R2

  AST_LOAD_CONSUMED: assert property (@(posedge clk) disable iff (!srst_n)
    (!ldac_n && busy_n && clr_n) |=> !pend_q); // R4

  AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!srst_n)
    !clr_n |=> (dac_codes == {NCH{$past(clear_code)}})); // R10

  AST_CLR_CANCELS: assert property (@(posedge clk) disable iff (!srst_n)
    !clr_n |=> !pend_q); // R10

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    overrun |=> overrun); // R9
endmodule

bind dac_regbank dac_regbank_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .srst_n(srst_n), .busy_n(busy_n), .overrun(overrun),
  .ldac_n(ldac_n), .clr_n(clr_n), .pend_q(pend_q),
  .clear_code(clear_code), .dac_codes(dac_codes)
);

// File: tb/dac_regbank_tb_top.sv
module dac_regbank_tb_top;
  localparam int W = 12;
  localparam int NCH = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [1:0]      wr_sel;
  logic [4:0]      wr_ch;
  logic [W-1:0]    wr_data;
  logic            ldac_n, clr_n;
  logic            busy_n, overrun;
  logic [NCH*W-1:0] dac_codes;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int exp_in [NCH];
  int exp_dac[NCH];
  int m_reg  [NCH];
  int c_reg  [NCH];
  int clr_code;

  always #4 clk = ~clk;

  dac_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
    .wr_data(wr_data), .ldac_n(ldac_n), .clr_n(clr_n),
    .busy_n(busy_n), .overrun(overrun), .dac_codes(dac_codes)
  );

  function automatic int cal(int d, int m, int c);
    int v;
    v = (d * (m + 1)) / 4096 + c - 2048;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_dac(string tag);
    int bad = -1;
    for (int k = 0; k < NCH; k++)
      if (bad < 0 && int'(dac_codes[k*W +: W]) != exp_dac[k]) bad = k;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s ch%0d", tag, bad), int'(dac_codes[bad*W +: W]), exp_dac[bad]);
  endtask

  // keep=0 marks a data write expected to be dropped
  task automatic do_write(int sel, int ch, int data, bit keep);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_ch = 5'(ch); wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: if (keep) exp_in[ch] = cal(data, m_reg[ch], c_reg[ch]);
      1: m_reg[ch] = data;
      2: c_reg[ch] = data;
      default: clr_code = data;
    endcase
  endtask

  task automatic strobe(bit ld, bit cl);
    @(negedge clk);
    ldac_n = !ld; clr_n = !cl;
    @(negedge clk);
    ldac_n = 1'b1; clr_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
  endtask

  task automatic model_load();
    for (int k = 0; k < NCH; k++) exp_dac[k] = exp_in[k];
  endtask

  task automatic model_clear();
    for (int k = 0; k < NCH; k++) exp_dac[k] = clr_code;
  endtask

  task automatic t_reset();
    chk(busy_n == 1'b1, "R1 busy_n after reset", int'(busy_n), 1);
    chk(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
    check_dac("R1 outputs after reset");
  endtask

  task automatic t_basic();
    int lows = 0;
    do_write(0, 3, 'h123, 1);
    while (!busy_n && lows < 40) begin lows++; @(negedge clk); end
    chk(lows == 16, "R3 busy_n low cycles", lows, 16);
    check_dac("R2 write leaves outputs unchanged");
    strobe(1, 0); model_load();
    check_dac("R1 R4 default gain/offset pass code through");
  endtask

  task automatic t_simul();
    do_write(0, 0, 'hABC, 1); wait_idle();
    do_write(0, 31, 'h001, 1); wait_idle();
    check_dac("R2 outputs held before load");
    strobe(1, 0); model_load();
    check_dac("R4 all channels load together");
  endtask

  task automatic t_cal();
    do_write(1, 10, 2047, 1);
    chk(busy_n == 1'b1, "R7 gain write not busy", int'(busy_n), 1);
    do_write(2, 10, 2148, 1);
    do_write(2, 11, 4095, 1);
    do_write(2, 12, 0, 1);
    do_write(1, 13, 1023, 1);
    chk(busy_n == 1'b1, "R7 offset/gain writes not busy", int'(busy_n), 1);
    do_write(0, 10, 1000, 1); wait_idle();
    do_write(0, 11, 4095, 1); wait_idle();
    do_write(0, 12, 100, 1);  wait_idle();
    do_write(0, 13, 4000, 1); wait_idle();
    strobe(1, 0); model_load();
    chk(exp_dac[10] == 600 && exp_dac[11] == 4095 && exp_dac[12] == 0 && exp_dac[13] == 1000,
        "R6 bench model values", exp_dac[10], 600);
    check_dac("R6 R7 calibrated and saturated codes");
  endtask

  task automatic t_defer();
    do_write(0, 20, 'h777, 1);
    strobe(1, 0);
    check_dac("R5 no load while busy");
    wait_idle();
    check_dac("R5 not loaded before first idle edge");
    @(negedge clk); model_load();
    check_dac("R5 deferred load after busy");
  endtask

  task automatic t_queue();
    int lows = 0;
    do_write(0, 5, 'h050, 1);
    do_write(0, 6, 'h060, 1);
    while (!busy_n && lows < 60) begin lows++; @(negedge clk); end
    chk(lows == 30, "R8 busy_n continuous through queued write", lows, 30);
    chk(overrun == 1'b0, "R8 no overrun with one queued", int'(overrun), 0);
    strobe(1, 0); model_load();
    check_dac("R8 both writes computed");
  endtask

  task automatic t_ovr();
    do_write(0, 7, 'h070, 1);
    do_write(0, 8, 'h080, 1);
    do_write(0, 9, 'h090, 0);
    chk(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    wait_idle();
    strobe(1, 0); model_load();
    check_dac("R9 dropped write has no effect");
    chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
  endtask

  task automatic t_clr();
    do_write(3, 0, 'h5A5, 1);
    strobe(0, 1); model_clear();
    check_dac("R10 clear loads clear code");
    do_write(0, 1, 'h111, 1);
    strobe(1, 0);
    strobe(0, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    check_dac("R10 clear cancels held-back load");
    do_write(3, 0, 'h0F0, 1);
    strobe(1, 1); model_clear();
    check_dac("R10 clear wins over concurrent load");
    strobe(1, 0); model_load();
    check_dac("R4 load after clear");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_ch = '0; wr_data = '0;
    ldac_n = 1'b1; clr_n = 1'b1;
    clr_code = 0;
    for (int k = 0; k < NCH; k++) begin
      exp_in[k] = 0; exp_dac[k] = 0; m_reg[k] = 4095; c_reg[k] = 2048;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_simul();
    t_cal();
    t_defer();
    t_queue();
    t_ovr();
    t_clr();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule